// File: doc/BRIEF.md
# Power-Up and Calibration Sequencer

This block is the state controller of a clock synthesizer. After a power-on reset it asks for the stored configuration to be copied into the working registers. It then waits for a reference clock and lets the oscillator settle for a fixed number of divided-input strobes. Next it runs VCO calibration for a fixed number of phase-detector strobes. When calibration ends it enables the dividers and outputs. It decodes the enables for the PLL, the output dividers and the output buffers from its current state.

Software drives a run bit, a PLL-reset bit, a calibration-select bit and a sync bit. An external power pin forces a shutdown that ends in a full reload. The soft run bit powers the device down and, when set again, recalibrates without a reload. With calibration-select at 1, a low-then-high toggle of the PLL-reset bit restarts calibration. Clearing the sync bit while active holds the dividers and outputs off until it is set again. The two counters advance only on their clock-enable strobes.

Top module: `pwrcal_seq`

## Requirements
- R1: After reset, reload_req is 1 and pll_en, div_en, out_en and cal_active are 0 until load_done is seen high. The block then drops reload_req and waits for a reference.
- R2: While waiting for a reference with ref_ok low, the block stays put with pll_en 1, cal_active 0, div_en 0 and out_en 0. ref_ok high starts the settle delay.
- R3: The settle delay ends on the DELAY_TICKS-th cycle with div_stb high. pfd_stb has no effect on the settle delay.
- R4: cal_active is 1 from the end of the settle delay until the CAL_TICKS-th cycle with pfd_stb high. During that time pll_en is 1 and div_en and out_en are 0. The block then enters active mode.
- R5: In active mode pll_en, div_en and out_en are all 1 and cal_active is 0.
- R6: pwr_pin low puts every enable and reload_req to 0 one cycle later, from any state. When pwr_pin returns high, reload_req rises and sel_clr pulses high for exactly one cycle.
- R7: soft_run low powers the block down (all enables 0) from any state after the configuration load. Setting soft_run high again returns to waiting for a reference with reload_req held at 0.
- R8: With cal_sel 1, a rising edge of pll_rst_bit that follows a low level restarts the reference wait, settle and calibration sequence. With cal_sel 0, pll_rst_bit has no effect.
- R9: In active mode, sync_run low disables div_en and out_en while pll_en stays 1. sync_run high then restores active mode.
- R10: pwr_pin low overrides every other input. While it is low, soft_run, pll_rst_bit and sync_run leave all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pwr_pin | input | 1 | External power pin, 0 = power down |
| soft_run | input | 1 | Register run bit, 0 = power down |
| pll_rst_bit | input | 1 | Register PLL-reset bit |
| cal_sel | input | 1 | Register calibration-select bit |
| sync_run | input | 1 | Register sync bit, 0 = hold dividers |
| ref_ok | input | 1 | Reference clock present |
| load_done | input | 1 | Configuration copy finished |
| div_stb | input | 1 | Divided-input clock enable |
| pfd_stb | input | 1 | Phase-detector clock enable |
| reload_req | output | 1 | Request to copy stored configuration |
| sel_clr | output | 1 | One-cycle pulse clearing cal_sel |
| cal_active | output | 1 | VCO calibration in progress |
| pll_en | output | 1 | PLL enable |
| div_en | output | 1 | Output divider enable |
| out_en | output | 1 | Output buffer enable |

## Verification
Every output is decoded from a state register, so each output answers one clock after the edge that samples the input causing it. The sel_clr pulse is registered together with the state move, so it appears in the same cycle. The bench applies inputs just after a rising edge, moves its own state model on the next rising edge, and compares all six outputs on the falling edge that follows. Settle and calibration are checked to the exact strobe: the bench runs both strobes at different periods, so a counter driven by the wrong strobe would show a different exit cycle.

// File: rtl/pwrcal_seq.sv
module pwrcal_seq #(
  parameter int DELAY_TICKS = 16384,
  parameter int CAL_TICKS   = 550
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_pin,
  input  logic soft_run,
  input  logic pll_rst_bit,
  input  logic cal_sel,
  input  logic sync_run,
  input  logic ref_ok,
  input  logic load_done,
  input  logic div_stb,
  input  logic pfd_stb,
  output logic reload_req,
  output logic sel_clr,
  output logic cal_active,
  output logic pll_en,
  output logic div_en,
  output logic out_en
);
  localparam int MAXT = (DELAY_TICKS > CAL_TICKS) ? DELAY_TICKS : CAL_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [2:0] {
    S_POR, S_WREF, S_SETTLE, S_CAL, S_ACT, S_SYNC, S_PDPIN, S_PDSOFT
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt;
  logic rst_prev;
  logic sel_clr_q;

  wire rst_rise   = pll_rst_bit & ~rst_prev;
  wire running    = (st == S_WREF) || (st == S_SETTLE) || (st == S_CAL) ||
                    (st == S_ACT)  || (st == S_SYNC);
  wire settle_end = (st == S_SETTLE) && div_stb && (cnt == CW'(DELAY_TICKS - 1));
  wire cal_end    = (st == S_CAL) && pfd_stb && (cnt == CW'(CAL_TICKS - 1));

  always_comb begin
    nx = st;
    if (!pwr_pin)                           nx = S_PDPIN;
    else if (running && !soft_run)          nx = S_PDSOFT;
    else if (running && cal_sel && rst_rise) nx = S_WREF;
    else begin
      case (st)
        S_POR:    if (load_done) nx = S_WREF;
        S_WREF:   if (ref_ok) nx = S_SETTLE;
        S_SETTLE: if (settle_end) nx = S_CAL;
        S_CAL:    if (cal_end) nx = S_ACT;
        S_ACT:    if (!sync_run) nx = S_SYNC;
        S_SYNC:   if (sync_run) nx = S_ACT;
        S_PDPIN:  nx = S_POR;
        S_PDSOFT: if (soft_run) nx = S_WREF;
        default:  nx = S_POR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_POR;
      cnt       <= '0;
      rst_prev  <= 1'b1;
      sel_clr_q <= 1'b0;
    end else begin
      st        <= nx;
      rst_prev  <= pll_rst_bit;
      sel_clr_q <= (st == S_PDPIN) && (nx == S_POR);
      if (nx != st)
        cnt <= '0;
      else if (((st == S_SETTLE) && div_stb) || ((st == S_CAL) && pfd_stb))
        cnt <= cnt + 1'b1;
    end
  end

  assign reload_req = (st == S_POR);
  assign sel_clr    = sel_clr_q;
  assign cal_active = (st == S_CAL);
  assign pll_en     = running;
  assign div_en     = (st == S_ACT);
  assign out_en     = (st == S_ACT);

  // R1
  por_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reload_req) |-> ($past(load_done) || !$past(pwr_pin)));

  // R3
  settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_active) |-> $past(div_stb));

  // R5
  out_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> ($past(cal_active) && $past(pfd_stb)) || $past(pll_en && !div_en && sync_run));

  // R6
  pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_pin |=> !pll_en && !div_en && !out_en && !reload_req && !cal_active);

  // R6
  sel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_clr |=> !sel_clr);

  // R7
  soft_noreload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en && !reload_req && pwr_pin && !$past(pwr_pin) == 1'b0 && soft_run && $past(!soft_run)) |-> !sel_clr);
endmodule

// File: tb/pwrcal_seq_test.sv
module pwrcal_seq_test;
  localparam int DT = 20;
  localparam int CT = 7;

  logic clk = 0;
  logic rst_n = 0, pwr_pin = 1, soft_run = 1, pll_rst_bit = 1, cal_sel = 0;
  logic sync_run = 1, ref_ok = 0, load_done = 0, div_stb = 0, pfd_stb = 0;
  logic reload_req, sel_clr, cal_active, pll_en, div_en, out_en;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  pwrcal_seq #(.DELAY_TICKS(DT), .CAL_TICKS(CT)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_pin(pwr_pin), .soft_run(soft_run),
    .pll_rst_bit(pll_rst_bit), .cal_sel(cal_sel), .sync_run(sync_run),
    .ref_ok(ref_ok), .load_done(load_done), .div_stb(div_stb), .pfd_stb(pfd_stb),
    .reload_req(reload_req), .sel_clr(sel_clr), .cal_active(cal_active),
    .pll_en(pll_en), .div_en(div_en), .out_en(out_en));

  always #2 clk = ~clk;

  // strobe generators: divided input every 3rd cycle, phase detector every 2nd
  int sc = 0;
  always @(posedge clk) begin
    #1;
    sc++;
    div_stb = (sc % 3 == 0);
    pfd_stb = (sc % 2 == 0);
  end

  // behavioural reference model: 0 por,1 wait ref,2 settle,3 cal,4 active,5 sync,6 pin down,7 soft down
  int m = 0, mc = 0;
  bit mprev = 1, mclr = 0;
  always @(posedge clk or negedge rst_n) begin
    int n;
    bit run;
    if (!rst_n) begin
      m = 0; mc = 0; mprev = 1; mclr = 0;
    end else begin
      run = (m >= 1 && m <= 5);
      n = m;
      if (!pwr_pin) n = 6;
      else if (run && !soft_run) n = 7;
      else if (run && cal_sel && pll_rst_bit && !mprev) n = 1;
      else if (m == 0) begin if (load_done) n = 1; end
      else if (m == 1) begin if (ref_ok) n = 2; end
      else if (m == 2) begin
        if (div_stb) begin
          if (mc + 1 == DT) n = 3;
          else mc++;
        end
      end
      else if (m == 3) begin
        if (pfd_stb) begin
          if (mc + 1 == CT) n = 4;
          else mc++;
        end
      end
      else if (m == 4) begin if (!sync_run) n = 5; end
      else if (m == 5) begin if (sync_run) n = 4; end
      else if (m == 6) n = 0;
      else if (m == 7) begin if (soft_run) n = 1; end
      mclr = (m == 6) && (n == 0);
      if (n != m) mc = 0;
      m = n;
      mprev = pll_rst_bit;
    end
  end

  function automatic string tag_of(int i);
    case (i)
      5: return "R1 reload_req";
      4: return "R6 sel_clr";
      3: return "R4 cal_active";
      2: return "R5 pll_en";
      1: return "R9 div_en";
      default: return "R5 out_en";
    endcase
  endfunction

  always @(negedge clk) begin
    logic [5:0] got, exp;
    got = {reload_req, sel_clr, cal_active, pll_en, div_en, out_en};
    exp = {m == 0, mclr, m == 3, (m >= 1 && m <= 5), m == 4, m == 4};
    for (int i = 0; i < 6; i++) begin
      n_cmp++;
      if (got[i] !== exp[i]) begin
        n_bad++;
        $display("FAIL %s cycle %0d: got %b expected %b", tag_of(i), cyc, got[i], exp[i]);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect6(string tag, logic [5:0] exp);
    logic [5:0] got;
    @(negedge clk);
    got = {reload_req, sel_clr, cal_active, pll_en, div_en, out_en};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // order: reload, sel_clr, cal, pll, div, out
  initial begin
    step(3);
    rst_n = 1;
    step(4);
    expect6("R1 held in load", 6'b100000);
    load_done = 1;
    step(10);
    expect6("R2 waiting for reference", 6'b000100);
    ref_ok = 1;
    step(40);
    expect6("R3 still settling", 6'b000100);
    step(40);
    expect6("R5 active after calibration", 6'b000111);
    // R9 sync hold
    sync_run = 0;
    step(4);
    expect6("R9 sync hold", 6'b000100);
    sync_run = 1;
    step(2);
    expect6("R9 sync release", 6'b000111);
    // R8 ignored with select low
    pll_rst_bit = 0; step(3); pll_rst_bit = 1;
    step(3);
    expect6("R8 reset ignored when cal_sel=0", 6'b000111);
    // R8 restart with select high
    cal_sel = 1;
    pll_rst_bit = 0; step(3); pll_rst_bit = 1;
    step(2);
    expect6("R8 restart on rising edge", 6'b000100);
    step(90);
    expect6("R4 recalibrated to active", 6'b000111);
    // R7 soft power-down
    soft_run = 0;
    step(3);
    expect6("R7 soft power-down", 6'b000000);
    soft_run = 1;
    step(2);
    expect6("R7 no reload after soft run", 6'b000100);
    step(64);
    // R6 / R10 pin power-down in the middle of calibration, with other bits moving
    pwr_pin = 0; load_done = 0;
    step(2);
    expect6("R6 pin power-down", 6'b000000);
    soft_run = 0; sync_run = 0; pll_rst_bit = 0;
    step(3);
    soft_run = 1; sync_run = 1; pll_rst_bit = 1;
    step(3);
    expect6("R10 pin overrides bits", 6'b000000);
    pwr_pin = 1;
    cal_sel = 0;
    @(posedge clk); #1;
    expect6("R6 reload with select clear pulse", 6'b110000);
    step(3);
    expect6("R6 reload held, pulse gone", 6'b100000);
    load_done = 1;
    step(100);
    expect6("R5 active after reload", 6'b000111);
    finish_run();
  end
endmodule